// File: doc/BRIEF.md
# Register Renamer with Rollback History

This block maps architectural registers onto a larger physical register file for one thread, one instruction per cycle. For each request it reads the current mappings of two source registers out of a map table and, when the instruction writes a destination, takes a fresh physical register from a pool of free ones. It then points the destination's map entry at that new register.

Every destination rename is logged as a record in an ordered history: the sequence number, the architectural register, the new physical register and the one it replaced. A commit that names the oldest record's sequence number retires that record and returns the replaced register to the pool. A squash undoes every record younger than the given sequence number, youngest first and one per cycle. While it does so, a busy flag keeps new renames out. Sequence numbers are 16-bit and compared modulo 2^16, so they may wrap.

Top module: `reg_rename_unit`

## Requirements
- R1: After reset, architectural register i maps to physical register i, physical registers NUM_ARCH to NUM_PHYS-1 are free, the history is empty, and `stall` and `busy` are low.
- R2: `src0_phys` and `src1_phys` show the current map entries of `ren_src0` and `ren_src1` in the same cycle. A destination mapping written at a clock edge is visible to sources from the next cycle onward.
- R3: An accepted request with `ren_has_dst`=1 takes the lowest-numbered free physical register and shows it on `dst_phys` in the same cycle. The map entry of `ren_dst` becomes that register at the next edge.
- R4: An accepted request with `ren_has_dst`=0 allocates nothing, changes no map entry and adds no history record.
- R5: When `commit_valid` is high, the history is non-empty and `commit_seq` equals the oldest record's sequence number, that record is removed and its replaced register becomes free at the next edge. A commit whose number does not match is ignored.
- R6: A cycle with `squash_valid` high raises `busy` from the next cycle. In each busy cycle, if the youngest record is younger than the latched squash number, it is removed: its map entry goes back to the replaced register and its new register becomes free. `busy` falls after the first busy cycle in which no such record remains, so k undone records take k+1 busy cycles.
- R7: With no free physical register, `stall` is high. `regs_full` is high in any cycle with `ren_valid`=1, `ren_has_dst`=1 and an empty pool.
- R8: With NUM_HIST records in the history, `stall` is high.
- R9: `stall` is also high while `busy` is high and in any cycle with `squash_valid` high. `ren_accept` = `ren_valid` and not `stall`. A commit in such a cycle is ignored.
- R10: Sequence number a is younger than b exactly when (a - b) mod 65536 lies in 1..32767, so the ordering holds across the wrap from 65535 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | Rename request present |
| ren_seq | input | 16 | Sequence number of the request |
| ren_src0 | input | 5 | First source architectural register |
| ren_src1 | input | 5 | Second source architectural register |
| ren_dst | input | 5 | Destination architectural register |
| ren_has_dst | input | 1 | Request writes a destination |
| ren_accept | output | 1 | Request renamed this cycle |
| src0_phys | output | 6 | Physical register of first source |
| src1_phys | output | 6 | Physical register of second source |
| dst_phys | output | 6 | Newly assigned destination register |
| commit_valid | input | 1 | Commit present |
| commit_seq | input | 16 | Sequence number being committed |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | 16 | Youngest surviving sequence number |
| stall | output | 1 | Renaming blocked this cycle |
| busy | output | 1 | Rollback in progress |
| regs_full | output | 1 | Destination request met an empty pool |

## Verification
The hardest state to reach is a rollback that meets a full history, wrapped sequence numbers and a commit attempt that must be ignored, all at once. Renames must run the pool dry, commits must then retire part of the history, and a squash must cut the remaining records in the middle. The bench starts sequence numbers just below 65536 and fills the history until it stalls. It retires a few records and then squashes at the middle live record. During the random phase it keeps offering commits while busy is high.

// File: rtl/rn_pkg.sv
package rn_pkg;
  localparam int SEQ_W = 16;

  // wrap-safe ordering: a is younger than b
  function automatic logic seq_younger(input logic [SEQ_W-1:0] a,
                                       input logic [SEQ_W-1:0] b);
    logic [SEQ_W-1:0] d;
    d = a - b;
    return (d != '0) && !d[SEQ_W-1];
  endfunction
endpackage

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int NUM_ARCH = 32,
  parameter int NUM_PHYS = 64,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int PW = $clog2(NUM_PHYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd0_arch,
  input  logic [AW-1:0] rd1_arch,
  input  logic [AW-1:0] rd2_arch,
  output logic [PW-1:0] rd0_phys,
  output logic [PW-1:0] rd1_phys,
  output logic [PW-1:0] rd2_phys,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_arch,
  input  logic [PW-1:0] wr_phys,
  input  logic          rst_en,
  input  logic [AW-1:0] rst_arch,
  input  logic [PW-1:0] rst_phys
);
  logic [PW-1:0] map_q [NUM_ARCH];

  assign rd0_phys = map_q[rd0_arch];
  assign rd1_phys = map_q[rd1_arch];
  assign rd2_phys = map_q[rd2_arch];

  for (genvar g = 0; g < NUM_ARCH; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)
        map_q[g] <= PW'(g);
      else if (rst_en && rst_arch == AW'(g))
        map_q[g] <= rst_phys;
      else if (wr_en && wr_arch == AW'(g))
        map_q[g] <= wr_phys;
    end
  end

  // R6: a rollback restore never coincides with a rename write
  map_one_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && rst_en));
endmodule

// File: rtl/rn_free_pool.sv
module rn_free_pool #(
  parameter int NUM_ARCH = 32,
  parameter int NUM_PHYS = 64,
  localparam int PW = $clog2(NUM_PHYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          empty,
  output logic [PW-1:0] alloc_idx,
  input  logic          alloc_take,
  input  logic          rel0_en,
  input  logic [PW-1:0] rel0_idx,
  input  logic          rel1_en,
  input  logic [PW-1:0] rel1_idx
);
  logic [NUM_PHYS-1:0] free_q, free_d;
  logic found;

  // lowest-numbered free register
  always_comb begin
    alloc_idx = '0;
    found = 1'b0;
    for (int i = 0; i < NUM_PHYS; i++) begin
      if (!found && free_q[i]) begin
        alloc_idx = PW'(i);
        found = 1'b1;
      end
    end
  end

  assign empty = !found;

  always_comb begin
    free_d = free_q;
    if (alloc_take) free_d[alloc_idx] = 1'b0;
    if (rel0_en)    free_d[rel0_idx]  = 1'b1;
    if (rel1_en)    free_d[rel1_idx]  = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_PHYS; i++) free_q[i] <= (i >= NUM_ARCH);
    end else begin
      free_q <= free_d;
    end
  end

  // R7: nothing is taken from an empty pool
  no_take_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_take |-> !empty);
  // R5: a commit returns a register that was in use
  rel0_inuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel0_en |-> !free_q[rel0_idx]);
  // R6: a rollback returns a register that was in use
  rel1_inuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel1_en |-> !free_q[rel1_idx]);
endmodule

// File: rtl/rn_history.sv
module rn_history #(
  parameter int NUM_ARCH = 32,
  parameter int NUM_PHYS = 64,
  parameter int NUM_HIST = 32,
  localparam int SW = rn_pkg::SEQ_W,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int PW = $clog2(NUM_PHYS),
  localparam int HW = $clog2(NUM_HIST),
  localparam int CW = $clog2(NUM_HIST + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [SW-1:0] push_seq,
  input  logic [AW-1:0] push_arch,
  input  logic [PW-1:0] push_new,
  input  logic [PW-1:0] push_prev,
  input  logic          pop_head,
  input  logic          pop_tail,
  output logic          empty,
  output logic          full,
  output logic [SW-1:0] head_seq,
  output logic [PW-1:0] head_prev,
  output logic [SW-1:0] tail_seq,
  output logic [AW-1:0] tail_arch,
  output logic [PW-1:0] tail_new,
  output logic [PW-1:0] tail_prev
);
  logic [SW-1:0] seq_m  [NUM_HIST];
  logic [AW-1:0] arch_m [NUM_HIST];
  logic [PW-1:0] new_m  [NUM_HIST];
  logic [PW-1:0] prev_m [NUM_HIST];
  logic [HW-1:0] head_q, tail_q, last_idx;
  logic [CW-1:0] cnt_q;

  function automatic logic [HW-1:0] wrap_inc(input logic [HW-1:0] p);
    return (p == HW'(NUM_HIST - 1)) ? '0 : p + 1'b1;
  endfunction
  function automatic logic [HW-1:0] wrap_dec(input logic [HW-1:0] p);
    return (p == '0) ? HW'(NUM_HIST - 1) : p - 1'b1;
  endfunction

  assign last_idx  = wrap_dec(tail_q);
  assign empty     = (cnt_q == '0);
  assign full      = (cnt_q == CW'(NUM_HIST));
  assign head_seq  = seq_m[head_q];
  assign head_prev = prev_m[head_q];
  assign tail_seq  = seq_m[last_idx];
  assign tail_arch = arch_m[last_idx];
  assign tail_new  = new_m[last_idx];
  assign tail_prev = prev_m[last_idx];

  always_ff @(posedge clk) begin
    if (push) begin
      seq_m[tail_q]  <= push_seq;
      arch_m[tail_q] <= push_arch;
      new_m[tail_q]  <= push_new;
      prev_m[tail_q] <= push_prev;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (pop_head) head_q <= wrap_inc(head_q);
      if (push)          tail_q <= wrap_inc(tail_q);
      else if (pop_tail) tail_q <= last_idx;
      case ({push, pop_head | pop_tail})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!full || pop_head));
  // R5
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_head || pop_tail) |-> !empty);
  // R6: rollback pops are exclusive with pushes and commits
  tail_pop_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_tail |-> !(push || pop_head));
endmodule

// File: rtl/reg_rename_unit.sv
module reg_rename_unit #(
  parameter int NUM_ARCH = 32,
  parameter int NUM_PHYS = 64,
  parameter int NUM_HIST = 32,
  localparam int SW = rn_pkg::SEQ_W,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int PW = $clog2(NUM_PHYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ren_valid,
  input  logic [SW-1:0] ren_seq,
  input  logic [AW-1:0] ren_src0,
  input  logic [AW-1:0] ren_src1,
  input  logic [AW-1:0] ren_dst,
  input  logic          ren_has_dst,
  output logic          ren_accept,
  output logic [PW-1:0] src0_phys,
  output logic [PW-1:0] src1_phys,
  output logic [PW-1:0] dst_phys,
  input  logic          commit_valid,
  input  logic [SW-1:0] commit_seq,
  input  logic          squash_valid,
  input  logic [SW-1:0] squash_seq,
  output logic          stall,
  output logic          busy,
  output logic          regs_full
);
  import rn_pkg::*;

  logic          busy_q;
  logic [SW-1:0] sq_seq_q;
  logic          pool_empty, hist_empty, hist_full;
  logic [PW-1:0] alloc_idx, dst_old_phys;
  logic          alloc_take, commit_hit, rb_pop;
  logic [SW-1:0] head_seq, tail_seq;
  logic [PW-1:0] head_prev, tail_new, tail_prev;
  logic [AW-1:0] tail_arch;

  // named internal events
  assign stall      = busy_q | squash_valid | pool_empty | hist_full;
  assign ren_accept = ren_valid & ~stall;
  assign alloc_take = ren_accept & ren_has_dst;
  assign regs_full  = ren_valid & ren_has_dst & pool_empty;
  assign commit_hit = commit_valid & ~busy_q & ~squash_valid & ~hist_empty &
                      (head_seq == commit_seq);
  assign rb_pop     = busy_q & ~hist_empty & seq_younger(tail_seq, sq_seq_q);
  assign busy       = busy_q;
  assign dst_phys   = alloc_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      sq_seq_q <= '0;
    end else if (busy_q) begin
      busy_q <= rb_pop;
    end else if (squash_valid) begin
      busy_q   <= 1'b1;
      sq_seq_q <= squash_seq;
    end
  end

  rn_map_table #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) map_i (
    .clk(clk), .rst_n(rst_n),
    .rd0_arch(ren_src0), .rd1_arch(ren_src1), .rd2_arch(ren_dst),
    .rd0_phys(src0_phys), .rd1_phys(src1_phys), .rd2_phys(dst_old_phys),
    .wr_en(alloc_take), .wr_arch(ren_dst), .wr_phys(alloc_idx),
    .rst_en(rb_pop), .rst_arch(tail_arch), .rst_phys(tail_prev)
  );

  rn_free_pool #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) pool_i (
    .clk(clk), .rst_n(rst_n),
    .empty(pool_empty), .alloc_idx(alloc_idx), .alloc_take(alloc_take),
    .rel0_en(commit_hit), .rel0_idx(head_prev),
    .rel1_en(rb_pop), .rel1_idx(tail_new)
  );

  rn_history #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS), .NUM_HIST(NUM_HIST)) hist_i (
    .clk(clk), .rst_n(rst_n),
    .push(alloc_take), .push_seq(ren_seq), .push_arch(ren_dst),
    .push_new(alloc_idx), .push_prev(dst_old_phys),
    .pop_head(commit_hit), .pop_tail(rb_pop),
    .empty(hist_empty), .full(hist_full),
    .head_seq(head_seq), .head_prev(head_prev),
    .tail_seq(tail_seq), .tail_arch(tail_arch),
    .tail_new(tail_new), .tail_prev(tail_prev)
  );

  // R9
  no_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ren_accept |-> !busy_q);
  // R7
  full_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    regs_full |-> !ren_accept);
  // R6
  busy_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && squash_valid) |=> busy_q);
  // R6: rollback ends only when no younger record remains
  busy_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && rb_pop) |=> busy_q);
endmodule

// File: tb/reg_rename_unit_tb_top.sv
module reg_rename_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NA = 32, NP = 64, NH = 32;

  logic clk = 0, rst_n = 0;
  logic ren_valid = 0, ren_has_dst = 0, commit_valid = 0, squash_valid = 0;
  logic [15:0] ren_seq = 0, commit_seq = 0, squash_seq = 0;
  logic [4:0] ren_src0 = 0, ren_src1 = 0, ren_dst = 0;
  logic ren_accept, stall, busy, regs_full;
  logic [5:0] src0_phys, src1_phys, dst_phys;

  always #(CLK_PERIOD/2) clk = ~clk;

  reg_rename_unit #(.NUM_ARCH(NA), .NUM_PHYS(NP), .NUM_HIST(NH)) dut_i (.*);

  typedef struct { int seq; int arch; int nw; int pv; } rec_t;
  rec_t hist[$];
  int map_m [NA];
  bit free_m [NP];
  bit mbusy;
  int msq;
  int vectors = 0, miscompares = 0;
  int seq_ctr = 16'hFFF0;
  string tag = "R1";

  function automatic bit younger(int a, int b);
    int d = (a - b) & 16'hFFFF;
    return d >= 1 && d <= 32767;
  endfunction

  function automatic int lowest_free();
    for (int i = 0; i < NP; i++) if (free_m[i]) return i;
    return -1;
  endfunction

  task automatic chk(string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    hist.delete();
    for (int i = 0; i < NA; i++) map_m[i] = i;
    for (int i = 0; i < NP; i++) free_m[i] = (i >= NA);
    mbusy = 0; msq = 0;
  endtask

  // expected combinational outputs for current inputs and model state
  task automatic compare();
    bit e_stall, e_acc, e_full;
    e_full  = lowest_free() < 0;
    e_stall = mbusy || squash_valid || e_full || hist.size() == NH;
    e_acc   = ren_valid && !e_stall;
    chk("stall(R7/R8/R9)", stall, e_stall);
    chk("accept(R9)", ren_accept, e_acc);
    chk("busy(R6)", busy, mbusy);
    chk("regs_full(R7)", regs_full, ren_valid && ren_has_dst && e_full);
    chk("src0(R2)", src0_phys, map_m[ren_src0]);
    chk("src1(R2)", src1_phys, map_m[ren_src1]);
    if (e_acc && ren_has_dst) chk("dst(R3)", dst_phys, lowest_free());
  endtask

  // state update at a clock edge, from pre-edge state
  task automatic model_step();
    bit e_stall, acc, cmt;
    int n;
    e_stall = mbusy || squash_valid || lowest_free() < 0 || hist.size() == NH;
    acc = ren_valid && !e_stall;
    cmt = commit_valid && !mbusy && !squash_valid && hist.size() > 0 &&
          hist[0].seq == commit_seq;
    if (mbusy) begin
      if (hist.size() > 0 && younger(hist[$].seq, msq)) begin
        rec_t r = hist.pop_back();
        map_m[r.arch] = r.pv;
        free_m[r.nw] = 1;
      end else mbusy = 0;
    end else if (squash_valid) begin
      mbusy = 1; msq = squash_seq;
    end
    n = lowest_free();
    if (cmt) begin
      free_m[hist[0].pv] = 1;
      void'(hist.pop_front());
    end
    if (acc) begin
      if (ren_has_dst) begin
        rec_t r;
        r.seq = ren_seq; r.arch = ren_dst; r.nw = n; r.pv = map_m[ren_dst];
        hist.push_back(r);
        map_m[ren_dst] = n;
        free_m[n] = 0;
      end
      seq_ctr = (seq_ctr + 1) & 16'hFFFF;
    end
  endtask

  task automatic cycle();
    #1;
    compare();
    @(posedge clk);
    model_step();
    @(negedge clk);
    ren_seq = seq_ctr[15:0];
  endtask

  task automatic clear_in();
    ren_valid = 0; ren_has_dst = 0; commit_valid = 0; squash_valid = 0;
  endtask

  task automatic rand_req(int pv, int pd);
    ren_valid   = ($urandom % 100) < pv;
    ren_has_dst = ($urandom % 100) < pd;
    ren_src0 = 5'($urandom); ren_src1 = 5'($urandom); ren_dst = 5'($urandom);
    ren_seq = seq_ctr[15:0];
  endtask

  task automatic do_squash();
    squash_valid = 1;
    squash_seq = (hist.size() > 2) ? 16'(hist[hist.size()/2].seq) : 16'(seq_ctr - 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset mapping is identity, no stall
    tag = "R1";
    for (int i = 0; i < NA; i++) begin
      ren_src0 = 5'(i); ren_src1 = 5'(NA - 1 - i);
      cycle();
    end
    // R2 R3 R4: mixed renames, dst present or absent
    tag = "R3";
    for (int i = 0; i < 20; i++) begin
      rand_req(100, 70);
      if (i % 5 == 0) begin tag = "R4"; ren_has_dst = 0; end else tag = "R3";
      cycle();
    end
    // R7 R8: fill pool and history until stall
    tag = "R8";
    for (int i = 0; i < 30; i++) begin rand_req(100, 100); cycle(); end
    // R5: retire oldest records, with a mismatched commit in between
    tag = "R5";
    clear_in();
    for (int i = 0; i < 10; i++) begin
      commit_valid = 1;
      commit_seq = (i == 3) ? 16'(hist[0].seq + 7) : 16'(hist[0].seq);
      cycle();
    end
    // R6 R10: squash at mid record across sequence wrap
    tag = "R6";
    clear_in();
    do_squash();
    seq_ctr = (squash_seq + 1) & 16'hFFFF;
    cycle();
    squash_valid = 0;
    tag = "R10";
    commit_valid = 1; commit_seq = 16'(hist.size() > 0 ? hist[0].seq : 0);
    for (int i = 0; i < 40; i++) begin rand_req(100, 100); cycle(); end
    // R9: random mix with commits during busy
    tag = "R9";
    for (int i = 0; i < 3000; i++) begin
      clear_in();
      rand_req(70, 80);
      if (($urandom % 100) < 40 && hist.size() > 0) begin
        commit_valid = 1; commit_seq = 16'(hist[0].seq);
      end
      if (!mbusy && ($urandom % 100) < 3) begin
        do_squash();
        seq_ctr = (squash_seq + 1) & 16'hFFFF;
        ren_seq = seq_ctr[15:0];
      end
      cycle();
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule